// File: doc/BRIEF.md
# Supply-Fail Protection and Host Reset Sequencer

This block guards a battery-backed memory array and its host processor against supply loss. It takes two digitized comparator flags. The first says the supply is above the write-protect trip level. The second says the supply is above the level at which the array can stay on the external rail instead of the backup cell. From these it drives a write-protect gate, an output-disable control for the array's data drivers, a pull-down enable for the host's open-drain reset line, and a backup-source select.

On a supply drop the block protects the array and pulls the host reset within a few clocks. It has four named states:

- `ST_DOWN`: protected and in reset.
- `ST_RECOV`: the recovery timer is running; still protected and in reset.
- `ST_HOLD`: the array is writable again, but the host is still held in reset.
- `ST_RUN`: normal operation.

The transitions are:

- `ST_DOWN` to `ST_RECOV` once the trip flag has stayed good through the glitch filter.
- `ST_RECOV` to `ST_HOLD` when the recovery tick count expires.
- `ST_HOLD` to `ST_RUN` when the total reset tick count expires.
- Any state to `ST_DOWN` as soon as the synchronized trip flag goes low. This discards any timer progress.

All delays are counted in ticks from an internal prescaler, so a simulation can use shortened values.

Top module: `supply_guard_seq`

## Requirements
- R1: While `arst_n` is low, and right after it rises with both flags low, `write_protect`, `out_disable`, `rst_pulldown` and `backup_sel` are all 1.
- R2: When `trip_ok` falls, `write_protect` and `rst_pulldown` are 1 after the third rising clock edge that samples it low (two synchronizer flops, then the state register).
- R3: `out_disable` equals `write_protect` in every cycle.
- R4: A high pulse on `trip_ok` shorter than `FILT_CLKS` clocks is ignored: protection and reset stay asserted.
- R5: With `TICK_DIV`=1, after `trip_ok` rises and stays high, `write_protect` first reads 0 after edge 3+`FILT_CLKS`+`REC_TICKS`.
- R6: With `TICK_DIV`=1, `rst_pulldown` first reads 0 after edge 3+`FILT_CLKS`+`RST_TICKS`. `RST_TICKS` > `REC_TICKS`, so protection always lifts before the reset is released. `rst_pulldown`=1 means the reset line is pulled low; 0 means it is released.
- R7: If `trip_ok` falls during either timer, protection and reset re-assert as in R2, and the next power-up takes the full R5/R6 times from zero.
- R8: With `TICK_DIV`=D>1, the release edges of R5 and R6 fall within [base+1+(N-1)·D, base+N·D]. Here base is 3+`FILT_CLKS` and N is the relevant tick count.
- R9: `backup_sel` equals the inverse of `bak_ok` delayed by two clock edges (two synchronizer flops); 1 selects the backup cell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low block reset |
| trip_ok | input | 1 | Comparator flag: supply above write-protect trip level |
| bak_ok | input | 1 | Comparator flag: supply above backup switchover level |
| write_protect | output | 1 | 1 blocks all writes; memory controls are don't-care |
| out_disable | output | 1 | 1 forces array data outputs to high impedance |
| rst_pulldown | output | 1 | 1 pulls the open-drain host reset low |
| backup_sel | output | 1 | 1 selects backup cell, 0 selects external supply |

## Verification
The bench builds two copies of the block with `FILT_CLKS`=3, `REC_TICKS`=5 and `RST_TICKS`=12. One has `TICK_DIV`=1, so every release edge can be computed exactly. The other has `TICK_DIV`=4, which exercises the prescaler phase windows. These short counts make it practical to sweep every glitch length below the filter length, and to drop the supply at every cycle offset through both power-up timers and a few cycles past them. Each restart is then re-measured in full.

// File: rtl/sgs_pkg.sv
package sgs_pkg;
    typedef enum logic [1:0] {
        ST_DOWN  = 2'd0,
        ST_RECOV = 2'd1,
        ST_HOLD  = 2'd2,
        ST_RUN   = 2'd3
    } sgs_state_t;
endpackage

// File: rtl/sgs_sync.sv
module sgs_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= din;
            stab_q <= meta_q;
        end
    end

    assign dout = stab_q;
endmodule

// File: rtl/sgs_deglitch.sv
module sgs_deglitch #(
    parameter int LEN = 8
) (
    input  logic clk,
    input  logic arst_n,
    input  logic din,
    output logic good
);
    localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;

    logic [CW-1:0] run_q;
    logic          good_q;

    // Goes high after LEN consecutive high samples; any low sample clears at once.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            run_q  <= '0;
            good_q <= 1'b0;
        end else if (!din) begin
            run_q  <= '0;
            good_q <= 1'b0;
        end else if (!good_q) begin
            if (run_q == CW'(LEN - 1)) begin
                good_q <= 1'b1;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign good = good_q;
endmodule

// File: rtl/sgs_prescale.sv
module sgs_prescale #(
    parameter int DIV = 1000
) (
    input  logic clk,
    input  logic arst_n,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_pass
            assign tick = 1'b1;
        end else begin : g_div
            localparam int PW = $clog2(DIV);
            logic [PW-1:0] div_q;
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) begin
                    div_q <= '0;
                end else if (div_q == PW'(DIV - 1)) begin
                    div_q <= '0;
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end
            assign tick = (div_q == PW'(DIV - 1));
        end
    endgenerate
endmodule

// File: rtl/supply_guard_seq.sv
module supply_guard_seq #(
    parameter int TICK_DIV  = 1000,
    parameter int FILT_CLKS = 8,
    parameter int REC_TICKS = 125,
    parameter int RST_TICKS = 200
) (
    input  logic clk,
    input  logic arst_n,
    input  logic trip_ok,
    input  logic bak_ok,
    output logic write_protect,
    output logic out_disable,
    output logic rst_pulldown,
    output logic backup_sel
);
    import sgs_pkg::*;

    localparam int HOLD_TICKS = RST_TICKS - REC_TICKS;
    localparam int CW         = $clog2(RST_TICKS + 1);

    logic [1:0]  flags_s;
    logic        trip_s;
    logic        bak_s;
    logic        trip_good;
    logic        tick;
    sgs_state_t  state_q;
    sgs_state_t  state_d;
    logic [CW-1:0] tcnt_q;

    sgs_sync #(.W(2)) u_sync (
        .clk    (clk),
        .arst_n (arst_n),
        .din    ({bak_ok, trip_ok}),
        .dout   (flags_s)
    );
    assign trip_s = flags_s[0];
    assign bak_s  = flags_s[1];

    sgs_deglitch #(.LEN(FILT_CLKS)) u_filt (
        .clk    (clk),
        .arst_n (arst_n),
        .din    (trip_s),
        .good   (trip_good)
    );

    sgs_prescale #(.DIV(TICK_DIV)) u_pre (
        .clk    (clk),
        .arst_n (arst_n),
        .tick   (tick)
    );

    // Next-state: a low synchronized trip flag overrides every state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DOWN:  if (trip_good) state_d = ST_RECOV;
            ST_RECOV: if (tick && tcnt_q == CW'(REC_TICKS - 1)) state_d = ST_HOLD;
            ST_HOLD:  if (tick && tcnt_q == CW'(HOLD_TICKS - 1)) state_d = ST_RUN;
            ST_RUN:   state_d = ST_RUN;
        endcase
        if (!trip_s) state_d = ST_DOWN;
    end

    // State register and stage timer.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state_q <= ST_DOWN;
            tcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) begin
                tcnt_q <= '0;
            end else if (tick && (state_q == ST_RECOV || state_q == ST_HOLD)) begin
                tcnt_q <= tcnt_q + 1'b1;
            end
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        unique case (state_q)
            ST_DOWN, ST_RECOV: begin
                write_protect = 1'b1;
                rst_pulldown  = 1'b1;
            end
            ST_HOLD: begin
                write_protect = 1'b0;
                rst_pulldown  = 1'b1;
            end
            ST_RUN: begin
                write_protect = 1'b0;
                rst_pulldown  = 1'b0;
            end
        endcase
        out_disable = write_protect;
        backup_sel  = !bak_s;
    end
endmodule

// File: rtl/sgs_checker.sv
module sgs_checker (
    input logic clk,
    input logic arst_n,
    input logic trip_ok,
    input logic bak_ok,
    input logic write_protect,
    input logic out_disable,
    input logic rst_pulldown,
    input logic backup_sel
);
    // R2: three low samples of the trip flag force protection and reset.
    p_fail_protect_r2: assert property (@(posedge clk) disable iff (!arst_n)
        (!trip_ok && !$past(trip_ok) && !$past(trip_ok, 2)) |=> (write_protect && rst_pulldown));

    // R3: drivers are disabled exactly when writes are blocked.
    p_od_tracks_r3: assert property (@(posedge clk) disable iff (!arst_n)
        out_disable == write_protect);

    // R6: reset is only released after protection was already off.
    p_wp_before_rst_r6: assert property (@(posedge clk) disable iff (!arst_n)
        $fell(rst_pulldown) |-> (!write_protect && $past(!write_protect)));

    // R7: protection never re-engages without reset being pulled as well.
    p_rearm_with_rst_r7: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(write_protect) |-> rst_pulldown);

    // R9: backup select follows the synchronized backup flag.
    p_bak_sel_r9: assert property (@(posedge clk) disable iff (!arst_n)
        (!bak_ok && !$past(bak_ok)) |=> backup_sel);

    p_bak_ext_r9: assert property (@(posedge clk) disable iff (!arst_n)
        (bak_ok && $past(bak_ok)) |=> !backup_sel);
endmodule

bind supply_guard_seq sgs_checker u_chk (.*);

// File: tb/tb_supply_guard_seq.sv
module tb_supply_guard_seq;
    localparam int F = 3;
    localparam int R = 5;
    localparam int T = 12;
    localparam int D = 4;
    localparam int BASE = 3 + F;

    logic clk = 1'b0;
    logic arst_n = 1'b0;
    logic trip_ok = 1'b0;
    logic bak_ok = 1'b0;
    logic wp, od, rpd, bsel;
    logic wp4, od4, rpd4, bsel4;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    supply_guard_seq #(.TICK_DIV(1), .FILT_CLKS(F), .REC_TICKS(R), .RST_TICKS(T)) dut (
        .clk(clk), .arst_n(arst_n), .trip_ok(trip_ok), .bak_ok(bak_ok),
        .write_protect(wp), .out_disable(od), .rst_pulldown(rpd), .backup_sel(bsel)
    );

    supply_guard_seq #(.TICK_DIV(D), .FILT_CLKS(F), .REC_TICKS(R), .RST_TICKS(T)) dut_div (
        .clk(clk), .arst_n(arst_n), .trip_ok(trip_ok), .bak_ok(bak_ok),
        .write_protect(wp4), .out_disable(od4), .rst_pulldown(rpd4), .backup_sel(bsel4)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Drop supply, check the R2 latency on both copies, let things settle.
    task automatic drop_and_check();
        int n_a = -1;
        int n_b = -1;
        trip_ok = 1'b0;
        for (int n = 1; n <= 6; n++) begin
            step();
            if (n_a < 0 && wp && rpd) n_a = n;
            if (n_b < 0 && wp4 && rpd4) n_b = n;
            if (od != wp) chk(0, "R3 od vs wp", od, wp);
        end
        chk(n_a == 3 || n_a == 1, "R2 fail latency", n_a, 3);
        chk(n_b == 3 || n_b == 1, "R2 fail latency div", n_b, 3);
        repeat (4) step();
    endtask

    // Raise supply and measure release edges on both copies.
    task automatic rise_and_measure(input string tag);
        int w1 = -1, r1 = -1, w4 = -1, r4 = -1;
        trip_ok = 1'b1;
        for (int n = 1; n <= 80; n++) begin
            step();
            if (w1 < 0 && !wp) w1 = n;
            if (r1 < 0 && !rpd) r1 = n;
            if (w4 < 0 && !wp4) w4 = n;
            if (r4 < 0 && !rpd4) r4 = n;
            if (od != wp || od4 != wp4) chk(0, "R3 od vs wp", od, wp);
        end
        chk(w1 == BASE + R, {tag, " R5 wp release"}, w1, BASE + R);
        chk(r1 == BASE + T, {tag, " R6 reset release"}, r1, BASE + T);
        chk(w4 >= BASE + 1 + (R - 1) * D && w4 <= BASE + R * D,
            {tag, " R8 wp release div"}, w4, BASE + R * D);
        chk(r4 >= BASE + 1 + (T - 1) * D && r4 <= BASE + T * D,
            {tag, " R8 reset release div"}, r4, BASE + T * D);
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(wp && od && rpd && bsel, "R1 in reset", {wp, od, rpd, bsel}, 4'hF);
        arst_n = 1'b1;
        step();
        chk(wp && od && rpd && bsel && wp4 && rpd4, "R1 after reset", {wp, od, rpd, bsel}, 4'hF);

        // R9 backup select latency, both directions
        bak_ok = 1'b1;
        step();
        chk(bsel == 1'b1, "R9 bak edge1", bsel, 1);
        step();
        chk(bsel == 1'b0 && bsel4 == 1'b0, "R9 bak edge2 ext", bsel, 0);
        bak_ok = 1'b0;
        step();
        chk(bsel == 1'b0, "R9 bak fall edge1", bsel, 0);
        step();
        chk(bsel == 1'b1, "R9 bak fall edge2", bsel, 1);
        bak_ok = 1'b1;
        repeat (3) step();

        // R4 glitch sweep below filter length
        for (int len = 1; len < F; len++) begin
            int seen = 0;
            trip_ok = 1'b1;
            repeat (len) step();
            trip_ok = 1'b0;
            for (int n = 0; n < 20; n++) begin
                step();
                if (!wp || !rpd || !od) seen++;
            end
            chk(seen == 0, $sformatf("R4 glitch len %0d", len), seen, 0);
        end

        // R5 R6 R8 clean power-up, then R2 power-down
        rise_and_measure("clean");
        trip_ok = 1'b0;
        begin
            step(); step();
            chk(!wp && !rpd, "R2 not before edge3", {wp, rpd}, 0);
            step();
            chk(wp && rpd && od, "R2 fail at edge3", {wp, rpd, od}, 3'h7);
        end
        repeat (4) step();

        // R7 drop at every offset through both timers, then full re-measure
        for (int k = 1; k <= BASE + T + 3; k++) begin
            trip_ok = 1'b1;
            repeat (k) step();
            drop_and_check();
            rise_and_measure($sformatf("R7 restart k=%0d", k));
            drop_and_check();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule